// File: doc/BRIEF.md
# Boot Region Write Guard

This block sits between a flash command decoder and the embedded program/erase engine. It keeps the boot-region lockout setting and screens every program or erase request against it. A request whose byte range touches the protected region is refused with a one-cycle deny pulse. Any other request is forwarded to the engine with its address and kind unchanged.

The command decoder issues a single-cycle lock command that selects one of four regions: 16 KB or 64 KB, at the bottom or at the top of a 512 KB array. Once a region is locked, the lock stays in force until reset. Reset stands in for loading the non-volatile state. While the device is in identification mode, a status byte reports the lock. It can be read at one fixed address for the bottom region and at another fixed address for the top region.

Top module: `boot_lock_guard`

## Requirements
- R1: After reset no region is locked, `fwd_valid` and `deny` are low, and every identification read returns 8'h00.
- R2: A `lock_en` pulse while unlocked selects the region with `lock_large` (0 = 16 KB, 1 = 64 KB) and `lock_top` (0 = bottom, 1 = top).
- R3: A program request (`req_kind` = 0, one byte) outside the locked region, or any program request while unlocked, is forwarded: `fwd_valid` is high for one cycle and `fwd_addr`/`fwd_kind` equal the request.
- R4: The four regions are bottom 16 KB 00000h..03FFFh, bottom 64 KB 00000h..0FFFFh, top 16 KB 7C000h..7FFFFh and top 64 KB 70000h..7FFFFh. A program request to any byte inside the locked region is refused.
- R5: A page erase (`req_kind` = 1, the aligned 4 KB page holding the address) is refused if that page overlaps the locked region. The same rule applies to a sector erase (`req_kind` = 2, the aligned 64 KB sector).
- R6: A chip erase (`req_kind` = 3) is refused whenever any region is locked and forwarded when none is.
- R7: A `lock_en` pulse while a region is already locked has no effect. The region and the status bytes stay as they were.
- R8: Each request produces exactly one outcome, one cycle after `req_valid`. That outcome is either a one-cycle `deny` pulse or a forward, never both. A refused request forwards nothing.
- R9: `id_status` shows the lock one cycle after `id_addr` is applied. At address 00002h it gives the bottom lock and at 7FFF2h the top lock. The value is 8'h02 for a 16 KB lock, 8'h03 for a 64 KB lock, and 8'h00 for no lock there or for any other address. Bits 7..2 are always zero.
- R10: A request in the same cycle as the first `lock_en` is judged against the state before that lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the lock |
| lock_en | input | 1 | Single-cycle lock command from the decoder |
| lock_large | input | 1 | Region size with `lock_en`: 0 = 16 KB, 1 = 64 KB |
| lock_top | input | 1 | Region place with `lock_en`: 0 = bottom, 1 = top |
| req_valid | input | 1 | Program/erase request strobe |
| req_kind | input | 2 | 0 program, 1 page erase, 2 sector erase, 3 chip erase |
| req_addr | input | 19 | Byte address of the request |
| fwd_valid | output | 1 | Accepted request strobe to the engine |
| fwd_kind | output | 2 | Kind of the accepted request |
| fwd_addr | output | 19 | Address of the accepted request |
| deny | output | 1 | One-cycle pulse for a refused request |
| id_addr | input | 19 | Identification-mode read address |
| id_status | output | 8 | Lock status byte for `id_addr` |

## Verification
Every request result appears on the outputs exactly one clock edge after the request is strobed. A lock command takes effect at the edge that samples it, so a request issued with it still sees the old state. An identification read returns its byte one edge after the address is set. The bench drives inputs on the falling edge and stamps each expected outcome with its due cycle. A monitor samples at later falling edges, compares the outcome there, and flags any outcome that shows up early, late or unasked for. Status reads are checked at the falling edge that follows the capturing edge.

// File: rtl/boot_lock_pkg.sv
// Package: shared request kinds for the boot-region write guard.
// Assumes the command decoder encodes request kinds exactly as below.
package boot_lock_pkg;
    typedef enum logic [1:0] {
        KIND_PROG   = 2'd0,
        KIND_PAGE   = 2'd1,
        KIND_SECTOR = 2'd2,
        KIND_CHIP   = 2'd3
    } req_kind_e;

    localparam int KIND_COUNT = 4;
endpackage

// File: rtl/boot_lock_cfg.sv
// Module: boot_lock_cfg
// Holds the sticky lock setting. The first lock command after reset is
// captured; later commands are ignored until reset.
// Assumes reset models the power-up load of the non-volatile lock bits.
module boot_lock_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_en,
    input  logic lock_large,
    input  logic lock_top,
    output logic lock_on,
    output logic lock_is_large,
    output logic lock_is_top
);
    // Capture the first lock command; hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_on       <= 1'b0;
            lock_is_large <= 1'b0;
            lock_is_top   <= 1'b0;
        end else if (lock_en && !lock_on) begin
            lock_on       <= 1'b1;
            lock_is_large <= lock_large;
            lock_is_top   <= lock_top;
        end
    end

    // R7: an active lock can never change or drop before reset.
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |=> (lock_on && $stable(lock_is_large) && $stable(lock_is_top)));
endmodule

// File: rtl/boot_lock_region.sv
// Module: boot_lock_region
// Combinational check of whether a request's byte span overlaps the
// locked window. Each request kind gets its own aligned span.
// Assumes span sizes are powers of two and the array is 2**ADDR_W bytes.
module boot_lock_region
    import boot_lock_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SMALL_LOG  = 14,
    parameter int LARGE_LOG  = 16,
    parameter int PAGE_LOG   = 12,
    parameter int SECTOR_LOG = 16
) (
    input  logic              lock_on,
    input  logic              lock_is_large,
    input  logic              lock_is_top,
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int WW = ADDR_W + 1;
    localparam logic [WW-1:0] ONE         = WW'(1);
    localparam logic [WW-1:0] ARRAY_BYTES = ONE << ADDR_W;
    localparam logic [WW-1:0] SMALL_BYTES = ONE << SMALL_LOG;
    localparam logic [WW-1:0] LARGE_BYTES = ONE << LARGE_LOG;

    logic [WW-1:0] win_lo;
    logic [WW-1:0] win_hi;
    logic [WW-1:0] win_size;
    logic [KIND_COUNT-1:0] overlap;

    // Derive the inclusive bounds of the locked window.
    always_comb begin
        win_size = lock_is_large ? LARGE_BYTES : SMALL_BYTES;
        if (lock_is_top) begin
            win_lo = ARRAY_BYTES - win_size;
            win_hi = ARRAY_BYTES - ONE;
        end else begin
            win_lo = '0;
            win_hi = win_size - ONE;
        end
    end

    // One overlap test per request kind, each with its own span.
    for (genvar k = 0; k < KIND_COUNT; k++) begin : g_kind
        localparam int SPAN_LOG = (k == 0) ? 0 :
                                  (k == 1) ? PAGE_LOG :
                                  (k == 2) ? SECTOR_LOG : ADDR_W;
        localparam logic [WW-1:0] MASK = (ONE << SPAN_LOG) - ONE;
        logic [WW-1:0] span_lo;
        logic [WW-1:0] span_hi;
        assign span_lo    = {1'b0, addr} & ~MASK;
        assign span_hi    = {1'b0, addr} | MASK;
        assign overlap[k] = (span_hi >= win_lo) && (span_lo <= win_hi);
    end

    // Refuse only when a lock exists and the chosen span touches it.
    assign hit = lock_on && overlap[kind];
endmodule

// File: rtl/boot_lock_status.sv
// Module: boot_lock_status
// Registered identification-mode status byte. One fixed address reports
// the bottom lock and another reports the top lock.
// Assumes the decoder only samples id_status while in identification mode.
module boot_lock_status #(
    parameter int ADDR_W   = 19,
    parameter int BOT_OFS  = 2,
    parameter int TOP_BACK = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_on,
    input  logic              lock_is_large,
    input  logic              lock_is_top,
    input  logic [ADDR_W-1:0] id_addr,
    output logic [7:0]        id_status
);
    localparam logic [ADDR_W-1:0] BOT_ID = ADDR_W'(BOT_OFS);
    localparam logic [ADDR_W-1:0] TOP_ID = ADDR_W'((1 << ADDR_W) - TOP_BACK);

    logic [1:0] code;

    // Two-bit lock code: upper bit = locked, lower bit = large region.
    assign code = lock_on ? {1'b1, lock_is_large} : 2'b00;

    // Register the byte for the addressed location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_status <= 8'h00;
        end else if (id_addr == BOT_ID && !lock_is_top) begin
            id_status <= {6'b0, code};
        end else if (id_addr == TOP_ID && lock_is_top) begin
            id_status <= {6'b0, code};
        end else begin
            id_status <= 8'h00;
        end
    end

    // R9: with no lock held, the next status byte is zero.
    assert_status_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_on |=> (id_status == 8'h00));
endmodule

// File: rtl/boot_lock_guard.sv
// Module: boot_lock_guard (top)
// Screens program/erase requests against the sticky boot-region lock.
// Each request yields one registered outcome a cycle later: a forward
// or a deny pulse. Also serves the identification status byte.
// Assumes requests and lock commands are single-cycle strobes.
module boot_lock_guard
    import boot_lock_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SMALL_LOG  = 14,
    parameter int LARGE_LOG  = 16,
    parameter int PAGE_LOG   = 12,
    parameter int SECTOR_LOG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_en,
    input  logic              lock_large,
    input  logic              lock_top,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              deny,
    input  logic [ADDR_W-1:0] id_addr,
    output logic [7:0]        id_status
);
    logic      lock_on;
    logic      lock_is_large;
    logic      lock_is_top;
    logic      hit;
    req_kind_e kind;

    assign kind = req_kind_e'(req_kind);

    boot_lock_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_en      (lock_en),
        .lock_large   (lock_large),
        .lock_top     (lock_top),
        .lock_on      (lock_on),
        .lock_is_large(lock_is_large),
        .lock_is_top  (lock_is_top)
    );

    boot_lock_region #(
        .ADDR_W    (ADDR_W),
        .SMALL_LOG (SMALL_LOG),
        .LARGE_LOG (LARGE_LOG),
        .PAGE_LOG  (PAGE_LOG),
        .SECTOR_LOG(SECTOR_LOG)
    ) u_region (
        .lock_on      (lock_on),
        .lock_is_large(lock_is_large),
        .lock_is_top  (lock_is_top),
        .kind         (kind),
        .addr         (req_addr),
        .hit          (hit)
    );

    boot_lock_status #(
        .ADDR_W(ADDR_W)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_on      (lock_on),
        .lock_is_large(lock_is_large),
        .lock_is_top  (lock_is_top),
        .id_addr      (id_addr),
        .id_status    (id_status)
    );

    // Register each request's outcome: forward it or pulse deny.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            deny      <= 1'b0;
            fwd_kind  <= '0;
            fwd_addr  <= '0;
        end else begin
            fwd_valid <= req_valid && !hit;
            deny      <= req_valid && hit;
            if (req_valid) begin
                fwd_kind <= req_kind;
                fwd_addr <= req_addr;
            end
        end
    end

    // R8: never both outcomes at once.
    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(deny && fwd_valid));

    // R8: an outcome always traces back to a request one cycle earlier.
    assert_outcome_has_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (deny || fwd_valid) |-> $past(req_valid));

    // R6: a chip erase against an existing lock is refused next cycle.
    assert_chip_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_on && req_valid && req_kind == 2'd3) |=> (deny && !fwd_valid));
endmodule

// File: tb/tb_boot_lock_guard.sv
module tb_boot_lock_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_en = 1'b0;
    logic        lock_large = 1'b0;
    logic        lock_top = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [18:0] req_addr = '0;
    logic        fwd_valid;
    logic [1:0]  fwd_kind;
    logic [18:0] fwd_addr;
    logic        deny;
    logic [18:0] id_addr = '0;
    logic [7:0]  id_status;

    int checks = 0;
    int bad = 0;
    int cycle = 0;
    bit done = 0;

    typedef struct {
        bit          exp_deny;
        logic [18:0] addr;
        logic [1:0]  kind;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Bench lock model
    bit m_on = 0;
    bit m_large = 0;
    bit m_top = 0;
    int m_lo = 0;
    int m_hi = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cycle <= cycle + 1;

    boot_lock_guard dut (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .lock_large(lock_large),
        .lock_top(lock_top), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .fwd_valid(fwd_valid), .fwd_kind(fwd_kind),
        .fwd_addr(fwd_addr), .deny(deny), .id_addr(id_addr), .id_status(id_status)
    );

    function automatic bit want_deny(int kind, int addr);
        int span;
        int s;
        int e;
        span = (kind == 0) ? 1 : (kind == 1) ? 4096 : (kind == 2) ? 65536 : 524288;
        s = addr & ~(span - 1);
        e = s + span - 1;
        return m_on && (e >= m_lo) && (s <= m_hi);
    endfunction

    task automatic fail(string tag, string what, int act, int exp);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            lock_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        idle(2);
        rst_n = 1'b0;
        m_on = 0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Driver: one request, expected outcome pushed to the scoreboard.
    task automatic send_req(int kind, int addr, string tag, bit with_lock = 0,
                            bit lg = 0, bit tp = 0);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = kind[1:0];
        req_addr = addr[18:0];
        lock_en = with_lock;
        lock_large = lg;
        lock_top = tp;
        it.exp_deny = want_deny(kind, addr);
        it.addr = addr[18:0];
        it.kind = kind[1:0];
        it.due = cycle + 1;
        it.tag = tag;
        sb.push_back(it);
        if (with_lock && !m_on) begin
            m_on = 1; m_large = lg; m_top = tp;
            m_lo = tp ? (lg ? 'h70000 : 'h7C000) : 0;
            m_hi = tp ? 'h7FFFF : (lg ? 'hFFFF : 'h3FFF);
        end
    endtask

    task automatic lock_cmd(bit lg, bit tp);
        @(negedge clk);
        req_valid = 1'b0;
        lock_en = 1'b1;
        lock_large = lg;
        lock_top = tp;
        if (!m_on) begin
            m_on = 1; m_large = lg; m_top = tp;
            m_lo = tp ? (lg ? 'h70000 : 'h7C000) : 0;
            m_hi = tp ? 'h7FFFF : (lg ? 'hFFFF : 'h3FFF);
        end
        @(negedge clk);
        lock_en = 1'b0;
    endtask

    task automatic check_id(int addr, string tag);
        int exp;
        @(negedge clk);
        req_valid = 1'b0;
        lock_en = 1'b0;
        id_addr = addr[18:0];
        exp = 0;
        if (m_on && ((addr == 2 && !m_top) || (addr == 'h7FFF2 && m_top)))
            exp = m_large ? 3 : 2;
        @(negedge clk);
        checks++;
        if (id_status !== exp[7:0]) fail(tag, "id_status", id_status, exp);
    endtask

    // Monitor: compare outcomes in their due cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].due < cycle) begin
                fail(sb[0].tag, "missing outcome", 0, 1);
                void'(sb.pop_front());
            end
            if (fwd_valid || deny) begin
                checks++;
                if (sb.size() == 0 || sb[0].due != cycle) begin
                    fail("R8", "unexpected outcome", {fwd_valid, deny}, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    if (deny !== it.exp_deny || fwd_valid !== !it.exp_deny)
                        fail(it.tag, "deny/fwd", {deny, fwd_valid}, {it.exp_deny, !it.exp_deny});
                    else if (fwd_valid && (fwd_addr !== it.addr || fwd_kind !== it.kind))
                        fail(it.tag, "fwd addr/kind", {fwd_kind, fwd_addr}, {it.kind, it.addr});
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fail("WDOG", "watchdog expired", cycle, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        checks++;
        if (fwd_valid !== 1'b0 || deny !== 1'b0) fail("R1", "outputs after reset", {fwd_valid, deny}, 0);
        check_id(2, "R1");
        check_id('h7FFF2, "R1");

        // R3/R6: unlocked, everything forwards
        send_req(0, 0, "R3");
        send_req(3, 'h12345, "R6");
        send_req(2, 'h7FFFF, "R3");
        idle(3);

        // R2/R4/R5/R6/R9/R7: each of the four regions
        for (int opt = 0; opt < 4; opt++) begin
            int lo;
            int hi;
            do_reset();
            lock_cmd(opt[0], opt[1]);   // R2
            lo = m_lo;
            hi = m_hi;
            check_id(2, "R9");
            check_id('h7FFF2, "R9");
            check_id('h00003, "R9");
            for (int k = 0; k < 4; k++) begin
                send_req(k, lo, (k == 0) ? "R4" : (k == 3) ? "R6" : "R5");
                send_req(k, hi, (k == 0) ? "R4" : (k == 3) ? "R6" : "R5");
                if (lo > 0) send_req(k, lo - 1, (k == 0) ? "R3" : (k == 3) ? "R6" : "R5");
                if (hi < 'h7FFFF) send_req(k, hi + 1, (k == 0) ? "R3" : (k == 3) ? "R6" : "R5");
                send_req(k, 'h40000, (k == 0) ? "R3" : (k == 3) ? "R6" : "R5");
            end
            idle(2);
            // R7: a second lock command changes nothing
            lock_cmd(!opt[0], !opt[1]);
            check_id(2, "R7");
            check_id('h7FFF2, "R7");
            send_req(0, opt[1] ? 0 : 'h7FFFF, "R7");
            send_req(0, opt[1] ? 'h6FFFF : 'h10000, "R7");
            idle(3);
        end

        // R10: request alongside the first lock command sees no lock
        do_reset();
        send_req(0, 'h100, "R10", 1, 0, 0);
        send_req(0, 'h100, "R10");
        send_req(1, 'h4000, "R5");
        send_req(2, 'h10000, "R5");
        idle(4);

        checks++;
        if (sb.size() != 0) fail("R8", "outcomes still pending", sb.size(), 0);
        finish_run();
    end
endmodule